// File: doc/BRIEF.md
# Double-to-single store narrowing converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a single-precision floating-point store writes to memory. A request is taken on `start_i` together with the operand. The result appears on `word_o` with a one-cycle `done_o` pulse. Operands whose exponent already fits the single format, and also zero, infinity and NaN, are narrowed by selecting bits, with no rounding. The result for these is ready one cycle after the request.

Operands whose biased exponent lies in the band 874..896 map onto single-precision subnormals. For these the block loads the significand, with its hidden one made explicit, into a shift engine. The engine shifts it right by one place per clock until the exponent reaches the single minimum of -126, which takes between 1 and 23 shifts. The block then packs the truncated fraction under a zero exponent field. Nonzero operands with a biased exponent below 874 return a zero that keeps the operand's sign. The block does not round, raise exception flags or write to memory.

Top module: `fp_store_narrow`

## Requirements
- R1: While and after reset, before any request is accepted, `done_o`, `busy_o` and `word_o` are all zero.
- R2: When the biased exponent E = `dbl_i[62:52]` is greater than 896, including E = 2047 (infinity and NaN), the result is `{dbl_i[63:62], dbl_i[58:29]}`. `done_o` is high in the first cycle after the accepting clock edge.
- R3: When `dbl_i[62:0]` is zero, the result is `{dbl_i[63:62], 30'b0}`, so the sign of zero is kept. The latency is the same as in R2.
- R4: When E is in 1..873, the result is `{dbl_i[63], 31'b0}`. The latency is the same as in R2.
- R5: When E is in 874..896, let n = 897 - E and M = `{1'b1, dbl_i[51:0]}` >> n, a 53-bit value. The result is `{dbl_i[63], 8'b0, M[51:29]}`, and the lower bits are dropped.
- R6: For an operand under R5, `done_o` is high in cycle n+1 after the accepting edge, one cycle per shift.
- R7: `done_o` is high for one cycle per accepted request. `word_o` holds its value until the next accepted request completes.
- R8: `busy_o` is high while shifts are pending. A `start_i` seen while `busy_o` is high is ignored and produces no result.
- R9: A request is accepted in the very cycle `done_o` is high, so requests can follow each other with no gap.
- R10: The operand 64'h4040266660000000 produces 32'h42013333.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when `busy_o` is low |
| dbl_i | input | 64 | Double-precision operand, sampled with the request |
| busy_o | output | 1 | Shift engine occupied |
| done_o | output | 1 | One-cycle result strobe |
| word_o | output | 32 | Single-precision result, held between results |

## Verification
Two events can fall in the same cycle: the completion of one request, signalled by the `done_o` pulse and the final `word_o`, and the acceptance of the next `start_i`. The bench provokes this in two ways. It issues a new request in the exact cycle the previous `done_o` is seen, once after a direct operand and once after a 23-shift subnormal. It then judges both results and both latencies against its own arithmetic model. The opposite case is a `start_i` during shifting, which must be dropped. The bench checks that the first operand's word arrives on time and that no second `done_o` follows.

// File: rtl/fpsn_pkg.sv
package fpsn_pkg;
  localparam int DBL_W      = 64;
  localparam int SGL_W      = 32;
  localparam int DBL_EXP_W  = 11;
  localparam int SGL_EXP_W  = 8;
  localparam int DBL_FRAC_W = DBL_W - 1 - DBL_EXP_W;
  localparam int SGL_FRAC_W = SGL_W - 1 - SGL_EXP_W;
  localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
  localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
  // subnormal band of biased double exponents
  localparam int SUB_HI     = DBL_BIAS - SGL_BIAS;
  localparam int SUB_LO     = SUB_HI - (SGL_FRAC_W - 1);
  localparam int MANT_W     = DBL_FRAC_W + 1;
  localparam int MAX_SHIFT  = SGL_FRAC_W;
  localparam int SHIFT_W    = $clog2(MAX_SHIFT + 1);
  // direct-path slice: skip sign, exp msb and the extra exponent bits
  localparam int DIR_TOP    = DBL_W - 3 - (DBL_EXP_W - SGL_EXP_W);
  localparam int DIR_BOT    = DIR_TOP - (SGL_W - 3);

  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,
    PATH_FLUSH  = 2'd1,
    PATH_SUB    = 2'd2
  } path_e;
endpackage

// File: rtl/fpsn_classify.sv
module fpsn_classify
  import fpsn_pkg::*;
(
  input  logic [DBL_W-1:0]   dbl_i,
  output path_e              path_o,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [DBL_EXP_W-1:0] exp_f;
  logic                 mag_zero;
  int unsigned          exp_u;

  assign exp_f    = dbl_i[DBL_W-2 -: DBL_EXP_W];
  assign mag_zero = (dbl_i[DBL_W-2:0] == '0);
  assign exp_u    = 32'(exp_f);

  always_comb begin
    shift_o = '0;
    if (exp_u > SUB_HI || mag_zero) begin
      path_o = PATH_DIRECT;
    end else if (exp_u >= SUB_LO) begin
      path_o  = PATH_SUB;
      shift_o = SHIFT_W'(SUB_HI + 1 - exp_u);
    end else begin
      path_o = PATH_FLUSH;
    end
  end
endmodule

// File: rtl/fpsn_pack.sv
module fpsn_pack
  import fpsn_pkg::*;
(
  input  logic [DBL_W-1:0] dbl_i,
  input  path_e            path_i,
  output logic [SGL_W-1:0] word_o
);
  always_comb begin
    if (path_i == PATH_FLUSH) word_o = {dbl_i[DBL_W-1], {(SGL_W-1){1'b0}}};
    else                      word_o = {dbl_i[DBL_W-1 -: 2], dbl_i[DIR_TOP:DIR_BOT]};
  end
endmodule

// File: rtl/fpsn_sub_engine.sv
module fpsn_sub_engine
  import fpsn_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               sign_i,
  input  logic [MANT_W-1:0]  mant_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               busy_o,
  output logic               fin_o,
  output logic [SGL_W-1:0]   word_o
);
  logic [MANT_W-1:0]  mant_q, mant_nx;
  logic [SHIFT_W-1:0] cnt_q;
  logic               sign_q, busy_q;

  assign mant_nx = mant_q >> 1;
  assign busy_o  = busy_q;
  assign fin_o   = busy_q && (cnt_q == SHIFT_W'(1));
  // packed from the value after the final shift
  assign word_o  = {sign_q, {SGL_EXP_W{1'b0}}, mant_nx[MANT_W-2 -: SGL_FRAC_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_q <= '0;
      cnt_q  <= '0;
      sign_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      mant_q <= mant_i;
      cnt_q  <= shift_i;
      sign_q <= sign_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      mant_q <= mant_nx;
      cnt_q  <= cnt_q - SHIFT_W'(1);
      if (cnt_q == SHIFT_W'(1)) busy_q <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q >= SHIFT_W'(1) && cnt_q <= SHIFT_W'(MAX_SHIFT))); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != SHIFT_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - SHIFT_W'(1))); // R6
endmodule

// File: rtl/fp_store_narrow.sv
module fp_store_narrow
  import fpsn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DBL_W-1:0] dbl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [SGL_W-1:0] word_o
);
  path_e              path;
  logic [SHIFT_W-1:0] shift_amt;
  logic [SGL_W-1:0]   pack_word, sub_word, word_q;
  logic               accept, sub_load, sub_busy, sub_fin, done_q;

  fpsn_classify u_classify (
    .dbl_i   (dbl_i),
    .path_o  (path),
    .shift_o (shift_amt)
  );

  fpsn_pack u_pack (
    .dbl_i  (dbl_i),
    .path_i (path),
    .word_o (pack_word)
  );

  assign accept   = start_i && !sub_busy;
  assign sub_load = accept && (path == PATH_SUB);

  fpsn_sub_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sub_load),
    .sign_i  (dbl_i[DBL_W-1]),
    .mant_i  ({1'b1, dbl_i[DBL_FRAC_W-1:0]}),
    .shift_i (shift_amt),
    .busy_o  (sub_busy),
    .fin_o   (sub_fin),
    .word_o  (sub_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else if (accept && !sub_load) begin
      word_q <= pack_word;
      done_q <= 1'b1;
    end else if (sub_fin) begin
      word_q <= sub_word;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = sub_busy;
  assign done_o = done_q;
  assign word_o = word_q;

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R8
  AST_SUB_EXP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> (word_o[SGL_W-2 -: SGL_EXP_W] == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(word_o) && !done_o)); // R7
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !done_o); // R8
endmodule

// File: tb/fp_store_narrow_tb.sv
module fp_store_narrow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dbl = '0;
  logic        busy, done;
  logic [31:0] word;
  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  fp_store_narrow dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .dbl_i (dbl),
    .busy_o (busy), .done_o (done), .word_o (word)
  );

  function automatic logic [31:0] model_word(input logic [63:0] d);
    int e = int'(d[62:52]);
    logic [52:0] m;
    if (e > 896 || d[62:0] == '0) return {d[63:62], d[58:29]};
    if (e < 874) return {d[63], 31'b0};
    m = {1'b1, d[51:0]} >> (897 - e);
    return {d[63], 8'b0, m[51:29]};
  endfunction

  function automatic int model_lat(input logic [63:0] d);
    int e = int'(d[62:52]);
    if (e > 896 || d[62:0] == '0 || e < 874) return 1;
    return 897 - e + 1;
  endfunction

  function automatic string tag_of(input logic [63:0] d);
    int e = int'(d[62:52]);
    if (d[62:0] == '0) return "R3";
    if (e > 896) return "R2";
    if (e < 874) return "R4";
    return "R5/R6";
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // waits at negedges; returns cycles until done seen (0 on timeout)
  task automatic wait_done(output int lat);
    lat = 0;
    for (int c = 1; c <= 100; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin lat = c; return; end
    end
  endtask

  task automatic run_op(input logic [63:0] d, input string req);
    int lat;
    @(negedge clk);
    dbl = d; start = 1'b1;
    wait_done(lat);
    check(lat == model_lat(d), {req, " latency"}, 64'(lat), 64'(model_lat(d)));
    check(word == model_word(d), req, 64'(word), 64'(model_word(d)));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [51:0] fr [3];
    logic [31:0] hold;
    fr[0] = 52'h0; fr[1] = 52'hF_FFFF_FFFF_FFFF; fr[2] = 52'h5_A5A5_A5A5_A5A5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !busy && word == '0, "R1", {31'b0, done, busy, word}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !busy && word == '0, "R1", {31'b0, done, busy, word}, 64'h0);

    // R10 known value
    run_op(64'h4040266660000000, "R10");
    check(word == 32'h42013333, "R10", 64'(word), 64'h42013333);

    // R3 signed zeros, R2 infinity and NaN
    run_op(64'h0, "R3");
    run_op(64'h8000000000000000, "R3");
    run_op(64'h7FF0000000000000, "R2");
    run_op(64'hFFF8000000000001, "R2");
    run_op(64'h7FF7FFFFFFFFFFFF, "R2");

    // sweep all exponents with three fractions, alternating sign
    for (int e = 0; e < 2048; e++)
      for (int f = 0; f < 3; f++) begin
        logic [63:0] d = {1'(e + f), 11'(e), fr[f]};
        run_op(d, tag_of(d));
      end

    // R7 hold after pulse
    run_op(64'h3800000000000123, "R5");
    hold = word;
    repeat (4) begin
      @(negedge clk);
      check(!done && word == hold, "R7", {31'b0, done, word}, {32'b0, hold});
    end

    // R8 start ignored while busy
    @(negedge clk);
    dbl = 64'hB6A0000000000000; start = 1'b1; // E=874, 23 shifts
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8 busy", 64'(busy), 64'h1);
    @(negedge clk);
    dbl = 64'h4040266660000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int c = 3; c <= 60; c++) begin
      if (done && lat == 0) lat = c;
      @(negedge clk);
    end
    check(lat == 24, "R8 latency", 64'(lat), 64'd24);
    check(word == model_word(64'hB6A0000000000000), "R8", 64'(word),
          64'(model_word(64'hB6A0000000000000)));
    check(!busy, "R8 idle", 64'(busy), 64'h0);

    // R9 back-to-back: new request in done cycle (direct then subnormal then direct)
    @(negedge clk);
    dbl = 64'h4040266660000000; start = 1'b1;
    wait_done(lat);
    check(lat == 1 && word == 32'h42013333, "R9", {lat[31:0], word}, {32'd1, 32'h42013333});
    dbl = 64'h36A0000000000000; start = 1'b1;
    wait_done(lat);
    check(lat == 24 && word == model_word(64'h36A0000000000000), "R9",
          {lat[31:0], word}, {32'd24, model_word(64'h36A0000000000000)});
    dbl = 64'hC000000000000000; start = 1'b1;
    wait_done(lat);
    check(lat == 1 && word == model_word(64'hC000000000000000), "R9",
          {lat[31:0], word}, {32'd1, model_word(64'hC000000000000000)});
    @(negedge clk);
    check(!done, "R7 pulse", 64'(done), 64'h0);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule